// File: doc/BRIEF.md
# Interrupt Coprocessor with Service-Routine Vectoring

This unit sits beside the fetch stage of a 32-bit core. Three external request lines, typically pushbuttons, are synchronized and edge-detected. Each rising edge leaves a pending bit that stays set until that source is serviced. While interrupts are enabled and any bit is pending, the unit takes an exception:

- it steers the next fetch to the fixed service entry 0x00000800;
- it saves the interrupted instruction's PC in an exception-PC register;
- it records which source won;
- it disables further interrupts.

A return instruction steers fetch back to the saved PC and turns interrupts on again. Software reaches the status, cause and exception-PC registers through coprocessor move reads and writes. Nested service is possible because software can save and restore the exception PC and re-enable interrupts inside a handler.

The unit also decodes the code address into two instruction banks of 512 words each. Word address bit 9 (byte address bit 11) picks the bank. The upper bank begins exactly at the service entry, so service routines live there and normal programs live in the lower bank. Both banks are modelled as arrays filled with a computed pattern.

Top module: `irq_cop`

## Requirements
- R1: Each of the three request lines `irq_i[k-1]` (source k = 1..3) passes a two-stage synchronizer. A rising edge then sets pending bit k, which reads back as bit 7+k of the cause register (select 13) and stays set until that source is accepted. A line held high sets its bit only once.
- R2: `take_o` is high in every cycle in which the enable bit is 1 and at least one pending bit is set. In that cycle `fetch_pc_o` equals 0x00000800.
- R3: When an exception is taken, the lowest-numbered pending source wins. Its number (1, 2 or 3) is written to cause bits [1:0], only its pending bit is cleared, and `cur_pc_i` is written to the exception PC.
- R4: The status register (select 14 is EPC, select 12 is status) holds the enable bit at bit 0. Taking an exception clears it, and a coprocessor write to select 12 loads it from write-data bit 0.
- R5: While `eret_i` is high and no exception is taken, `fetch_pc_o` equals the exception PC in the same cycle, and the enable bit is 1 from the next cycle.
- R6: When neither an exception nor a return is in progress, `fetch_pc_o` equals `seq_pc_i`.
- R7: A coprocessor write to select 14 loads the exception PC. Writes to select 13 have no effect, and reads of any select other than 12, 13 and 14 return zero.
- R8: `instr_o` comes from the bank chosen by `imem_addr_i[11]`, at word index `imem_addr_i[10:2]`; all other address bits are ignored. Lower-bank word i reads 0x0C0D0000+i, and upper-bank word i reads 0x5E7A0000+i.
- R9: While reset is low, the enable bit, the exception PC, the cause code and all pending bits read zero.
- R10: If an exception and a return happen in the same cycle, the exception wins. Fetch goes to 0x00000800, the exception PC takes `cur_pc_i`, and the enable bit becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 3 | Asynchronous interrupt request lines, source k on bit k-1 |
| cur_pc_i | input | 32 | PC of the instruction that an exception would interrupt |
| seq_pc_i | input | 32 | Next fetch address proposed by the datapath |
| eret_i | input | 1 | Return-from-exception instruction executes |
| cop_we_i | input | 1 | Coprocessor register write strobe |
| cop_sel_i | input | 5 | Coprocessor register select (12 status, 13 cause, 14 EPC) |
| cop_wdata_i | input | 32 | Coprocessor write data |
| cop_rdata_o | output | 32 | Coprocessor read data for the selected register |
| take_o | output | 1 | Exception is taken this cycle |
| fetch_pc_o | output | 32 | Next fetch address after redirection |
| imem_addr_i | input | 32 | Code byte address to read |
| instr_o | output | 32 | Instruction word read from the selected bank |

## Verification
A pending bit that is lost or set twice, or a wrong arbitration, shows up in the cause readout within a cycle. It also changes when `take_o` fires, and it leaves the wrong source code one cycle after the exception. A wrong enable bit shows as an exception that fires or stalls in the very next cycle that has a pending bit. A bad exception PC appears in `fetch_pc_o` on the first return and in the select-14 readout on the cycle after the exception. The bench runs a behavioural model in lockstep and compares every combinational output every cycle, so any such divergence is reported in the cycle it first becomes visible.

// File: rtl/irq_cop_pkg.sv
package irq_cop_pkg;
  localparam logic [4:0] SEL_STATUS = 5'd12;
  localparam logic [4:0] SEL_CAUSE  = 5'd13;
  localparam logic [4:0] SEL_EPC    = 5'd14;
  localparam int         PEND_LSB   = 8;
  localparam logic [15:0] BANK0_TAG = 16'h0C0D;
  localparam logic [15:0] BANK1_TAG = 16'h5E7A;
endpackage

// File: rtl/irq_cop_edge.sv
module irq_cop_edge #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      last_q <= '0;
    end else begin
      stg_q[0] <= raw_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      last_q <= stg_q[STAGES-1];
    end
  end

  assign rise_o = stg_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_cop_arb.sv
module irq_cop_arb #(
  parameter int N  = 3,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [CW-1:0] code_o
);
  // scan downward so the lowest set index is the final winner
  always_comb begin
    grant_o = '0;
    code_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        code_o     = CW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/irq_cop_rom.sv
module irq_cop_rom #(
  parameter int          AW  = 9,
  parameter int          DW  = 32,
  parameter logic [15:0] TAG = 16'h0000
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // placeholder image: tag in the upper half, word index in the lower half
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {TAG, 16'(i)};
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/irq_cop.sv
module irq_cop
  import irq_cop_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int N_IRQ       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ROM_AW      = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [XLEN-1:0]  cur_pc_i,
  input  logic [XLEN-1:0]  seq_pc_i,
  input  logic             eret_i,
  input  logic             cop_we_i,
  input  logic [4:0]       cop_sel_i,
  input  logic [XLEN-1:0]  cop_wdata_i,
  output logic [XLEN-1:0]  cop_rdata_o,
  output logic             take_o,
  output logic [XLEN-1:0]  fetch_pc_o,
  input  logic [XLEN-1:0]  imem_addr_i,
  output logic [XLEN-1:0]  instr_o
);
  localparam int CW       = $clog2(N_IRQ + 1);
  localparam int BANK_BIT = ROM_AW + 2;
  localparam logic [XLEN-1:0] VEC_ADDR = XLEN'(1) << BANK_BIT;

  logic [N_IRQ-1:0] rise, pend_q, grant;
  logic [CW-1:0]    win_code, code_q;
  logic             ie_q;
  logic [XLEN-1:0]  epc_q;
  logic             take;

  irq_cop_edge #(.N(N_IRQ), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (irq_i),
    .rise_o (rise)
  );

  irq_cop_arb #(.N(N_IRQ)) u_arb (
    .req_i   (pend_q),
    .grant_o (grant),
    .code_o  (win_code)
  );

  assign take = ie_q & (|pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      code_q <= '0;
      ie_q   <= 1'b0;
      epc_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~(take ? grant : '0)) | rise;
      if (take) begin
        code_q <= win_code;
        epc_q  <= cur_pc_i;
        ie_q   <= 1'b0;
      end else begin
        if (eret_i) ie_q <= 1'b1;
        else if (cop_we_i && cop_sel_i == SEL_STATUS) ie_q <= cop_wdata_i[0];
        if (cop_we_i && cop_sel_i == SEL_EPC) epc_q <= cop_wdata_i;
      end
    end
  end

  always_comb begin
    if (take)        fetch_pc_o = VEC_ADDR;
    else if (eret_i) fetch_pc_o = epc_q;
    else             fetch_pc_o = seq_pc_i;
  end

  always_comb begin
    cop_rdata_o = '0;
    case (cop_sel_i)
      SEL_STATUS: cop_rdata_o[0] = ie_q;
      SEL_CAUSE: begin
        cop_rdata_o[CW-1:0]             = code_q;
        cop_rdata_o[PEND_LSB +: N_IRQ] = pend_q;
      end
      SEL_EPC:    cop_rdata_o = epc_q;
      default:    cop_rdata_o = '0;
    endcase
  end

  assign take_o = take;

  // code space: two banks, upper bank begins at the service entry
  logic [XLEN-1:0] bank_data [2];
  for (genvar b = 0; b < 2; b++) begin : g_bank
    irq_cop_rom #(
      .AW  (ROM_AW),
      .DW  (XLEN),
      .TAG ((b == 0) ? BANK0_TAG : BANK1_TAG)
    ) u_rom (
      .addr_i (imem_addr_i[BANK_BIT-1:2]),
      .data_o (bank_data[b])
    );
  end

  assign instr_o = bank_data[imem_addr_i[BANK_BIT]];

  logic unused_addr;
  assign unused_addr = ^{imem_addr_i[XLEN-1:BANK_BIT+1], imem_addr_i[1:0]};
endmodule

// File: rtl/irq_cop_chk.sv
module irq_cop_chk #(
  parameter int XLEN  = 32,
  parameter int N_IRQ = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             take_i,
  input logic             eret_i,
  input logic [XLEN-1:0]  cur_pc_i,
  input logic [XLEN-1:0]  epc_i,
  input logic             ie_i,
  input logic [N_IRQ-1:0] pend_i,
  input logic [N_IRQ-1:0] grant_i
);
  a_r3_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  a_r3_grant_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i & ~pend_i) == '0);

  a_r3_epc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> epc_i == $past(cur_pc_i));

  a_r4_ie_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !ie_i);

  a_r5_eret_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !take_i) |=> ie_i);

  a_r1_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> (pend_i & $past(pend_i)) == $past(pend_i));

  a_r10_take_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && eret_i) |=> !ie_i);
endmodule

bind irq_cop irq_cop_chk #(.XLEN(XLEN), .N_IRQ(N_IRQ)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .take_i   (take),
  .eret_i   (eret_i),
  .cur_pc_i (cur_pc_i),
  .epc_i    (epc_q),
  .ie_i     (ie_q),
  .pend_i   (pend_q),
  .grant_i  (grant)
);

// File: tb/tb_irq_cop.sv
`timescale 1ns/1ps
module tb_irq_cop;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  irq_i = '0;
  logic [31:0] cur_pc_i = '0, seq_pc_i = '0, cop_wdata_i = '0, imem_addr_i = '0;
  logic        eret_i = 1'b0, cop_we_i = 1'b0;
  logic [4:0]  cop_sel_i = '0;
  logic [31:0] cop_rdata_o, fetch_pc_o, instr_o;
  logic        take_o;

  always #4 clk_i = ~clk_i;

  irq_cop dut (
    .clk_i, .rst_ni, .irq_i, .cur_pc_i, .seq_pc_i, .eret_i, .cop_we_i,
    .cop_sel_i, .cop_wdata_i, .cop_rdata_o, .take_o, .fetch_pc_o,
    .imem_addr_i, .instr_o
  );

  int total = 0, bad = 0, cyc_n = 0;

  // behavioural reference state
  logic [2:0]  m_s0 = '0, m_s1 = '0, m_q = '0, m_pend = '0;
  logic        m_ie = 1'b0;
  logic [31:0] m_epc = '0;
  logic [1:0]  m_code = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [2:0] p);
    int w = -1;
    for (int i = 2; i >= 0; i--) if (p[i]) w = i;
    return w;
  endfunction

  task automatic cyc(input logic [2:0] irq, input logic eret, input logic we,
                     input logic [4:0] sel, input logic [31:0] wd,
                     input logic [31:0] ia);
    logic        tk;
    int          w;
    logic [31:0] e_fetch, e_rd, e_ins;
    logic [2:0]  rise;
    @(negedge clk_i);
    cyc_n++;
    irq_i = irq; eret_i = eret; cop_we_i = we; cop_sel_i = sel;
    cop_wdata_i = wd; imem_addr_i = ia;
    cur_pc_i = 32'h0000_0100 + 32'(cyc_n) * 4;
    seq_pc_i = cur_pc_i + 4;
    #1;
    tk = m_ie && (m_pend != 0);
    w  = lowest(m_pend);
    e_fetch = tk ? 32'h800 : (eret ? m_epc : seq_pc_i);
    case (sel)
      5'd12:   e_rd = {31'b0, m_ie};
      5'd13:   e_rd = {21'b0, m_pend, 6'b0, m_code};
      5'd14:   e_rd = m_epc;
      default: e_rd = '0;
    endcase
    e_ins = {ia[11] ? 16'h5E7A : 16'h0C0D, 7'b0, ia[10:2]};
    chk("R2", "take", {31'b0, take_o}, {31'b0, tk});
    chk(tk && eret ? "R10" : tk ? "R2" : eret ? "R5" : "R6", "fetch", fetch_pc_o, e_fetch);
    chk(sel == 5'd12 ? "R4" : sel == 5'd13 ? "R1,R3" : "R7", "rdata", cop_rdata_o, e_rd);
    chk("R8", "instr", instr_o, e_ins);
    @(posedge clk_i);
    // R3 lowest pending wins; R4 clear on take; R5/R10 priority
    rise = m_s1 & ~m_q;
    m_q = m_s1; m_s1 = m_s0; m_s0 = irq;
    if (tk) begin
      m_pend[w] = 1'b0;
      m_code = 2'(w + 1);
      m_epc  = cur_pc_i;
      m_ie   = 1'b0;
    end else begin
      if (eret) m_ie = 1'b1;
      else if (we && sel == 5'd12) m_ie = wd[0];
      if (we && sel == 5'd14) m_epc = wd;
    end
    m_pend = m_pend | rise;
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9 reset state
    #3;
    cop_sel_i = 5'd12; #1; chk("R9", "status in reset", cop_rdata_o, 32'h0);
    cop_sel_i = 5'd13; #1; chk("R9", "cause in reset", cop_rdata_o, 32'h0);
    cop_sel_i = 5'd14; #1; chk("R9", "epc in reset", cop_rdata_o, 32'h0);
    chk("R9", "take in reset", {31'b0, take_o}, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    repeat (3) cyc(3'b000, 0, 0, 5'd13, 0, 32'h0);
    // R1 held level pends once while disabled
    repeat (6) cyc(3'b001, 0, 0, 5'd13, 0, 32'h0);
    repeat (2) cyc(3'b000, 0, 0, 5'd13, 0, 32'h4);
    // two more sources together
    cyc(3'b110, 0, 0, 5'd13, 0, 32'h7FC);
    repeat (4) cyc(3'b000, 0, 0, 5'd13, 0, 32'h800);
    // R4 enable: source 1 taken first, R3
    cyc(3'b000, 0, 1, 5'd12, 32'h1, 32'h804);
    repeat (2) cyc(3'b000, 0, 0, 5'd13, 0, 32'hFFC);
    cyc(3'b000, 0, 0, 5'd14, 0, 32'h0);
    // R5 return then next source
    cyc(3'b000, 1, 0, 5'd12, 0, 32'h808);
    repeat (2) cyc(3'b000, 0, 0, 5'd13, 0, 32'h10);
    cyc(3'b000, 1, 0, 5'd14, 0, 32'h10);
    repeat (2) cyc(3'b000, 0, 0, 5'd13, 0, 32'h10);
    cyc(3'b000, 1, 0, 5'd12, 0, 32'h10);
    repeat (2) cyc(3'b000, 0, 0, 5'd12, 0, 32'h10);
    // nesting: save epc by overwrite, re-enable, new request, restore, return (R7)
    cyc(3'b001, 0, 0, 5'd13, 0, 32'h0);
    repeat (4) cyc(3'b000, 0, 0, 5'd13, 0, 32'h0);
    cyc(3'b000, 0, 1, 5'd12, 32'h1, 32'h0);
    cyc(3'b100, 0, 0, 5'd14, 0, 32'h0);
    repeat (5) cyc(3'b000, 0, 0, 5'd14, 0, 32'h0);
    cyc(3'b000, 0, 1, 5'd14, 32'hCAFE_0010, 32'h0);
    cyc(3'b000, 1, 0, 5'd14, 0, 32'h0);
    // R10 return collides with take
    cyc(3'b010, 1, 0, 5'd13, 0, 32'h0);
    repeat (6) cyc(3'b000, 1, 0, 5'd13, 0, 32'h0);
    // R7 cause write ignored, unknown select reads zero
    cyc(3'b000, 0, 1, 5'd13, 32'hFFFF_FFFF, 32'h0);
    cyc(3'b000, 0, 0, 5'd13, 0, 32'h0);
    cyc(3'b000, 0, 1, 5'd3, 32'hFFFF_FFFF, 32'h0);
    cyc(3'b000, 0, 0, 5'd3, 0, 32'h0);
    // R8 bank decode, upper bits ignored
    for (int a = 0; a < 40; a++)
      cyc(3'b000, 0, 0, 5'd14, 0, 32'(a) * 32'h0000_0105 ^ 32'hF000_0003);
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [4:0] s;
      int r = $urandom % 4;
      s = (r == 0) ? 5'd12 : (r == 1) ? 5'd13 : (r == 2) ? 5'd14 : 5'd7;
      cyc(3'($urandom % 8 == 0 ? $urandom : 0), ($urandom % 10) == 0,
          ($urandom % 6) == 0, s, $urandom, $urandom);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule